// File: doc/BRIEF.md
# Path Trace Byte Transmit Sequencer

This block supplies the path trace byte that a transmit framer places in each outbound STS-3c synchronous payload envelope. A host writes a small register space: a 64-entry trace message store, a configuration register that selects the message length and the byte source, and a register that holds one fixed byte. Each time the framer pulses its per-envelope strobe, the block emits one byte with a one-clock valid flag.

When the source is the message store, a read index steps through the store one envelope at a time. It wraps at the configured length of 1, 16 or 64 bytes, so the far end sees the trace string repeat. When the source is the fixed register, every envelope carries that one host byte. The two remaining source codes send an all-zero byte. Any write to the configuration register restarts the message at its first byte.

Top module: `j1_trace_seq`

## Requirements
- R1: After reset, j1Byte is 0x00, j1Valid is 0, and the configuration register (address 64), the fixed byte (address 65) and every message store entry read as 0x00.
- R2: The configuration register at address 64 keeps written bits 3:2 as the length code and bits 1:0 as the source code; bits 7:4 always read as zero, whatever was written.
- R3: The length code gives the message length: 00 gives 1 byte, 01 gives 16 bytes, and 10 and 11 both give 64 bytes.
- R4: With source code 01, each strobe emits the message store entry at the read index; the index then advances by one and wraps to 0 after reaching length minus 1.
- R5: With source code 10, each strobe emits the fixed byte held at address 65.
- R6: With source code 00 or 11, each strobe emits 0x00 and the read index does not move.
- R7: Every write to address 64, even one that rewrites the same value, sets the read index to 0, so the next strobe in source code 01 emits entry 0. A strobe in the same cycle still uses the index and settings in force before the write.
- R8: j1Byte and j1Valid are registered: they change on the clock edge that samples speStrobe high. j1Valid is high for exactly one clock per strobe, and j1Byte holds its value between strobes.
- R9: A host write to the entry being read, or to the fixed byte, in the same cycle as a strobe makes the output carry the whole old byte; the new byte appears on the next visit.
- R10: hostRdata combinationally returns the message store entry for addresses 0 to 63, the configuration at 64, the fixed byte at 65, and 0x00 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Host write enable |
| hostAddr | input | 7 | Host address: 0-63 message store, 64 configuration, 65 fixed byte |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data for hostAddr |
| speStrobe | input | 1 | One-clock pulse per outbound envelope |
| j1Byte | output | 8 | Trace byte for the current envelope |
| j1Valid | output | 1 | One-clock flag marking a new j1Byte |

## Verification
On every cycle the assertions check the output timing: a valid pulse follows each strobe and no other cycle, and the byte holds between strobes. They also check that the zero-source codes give a zero byte while the read index stays put, that the index never passes the last position of the current length, that a configuration write restarts the index, and that the upper configuration bits read as zero. The actual byte sequence only shows up in the bench's scenarios, which compare it on every clock against a behavioural model. That covers wrapping at each of the three lengths, the restart after a rewrite of the same value, the fixed-byte source, and the old-byte result when a write collides with a strobe.

// File: rtl/j1_trace_pkg.sv
package j1_trace_pkg;

  // Output source chosen by the control for each strobe
  typedef enum logic [1:0] {
    SEL_ZERO = 2'd0,
    SEL_MSG  = 2'd1,
    SEL_FIX  = 2'd2
  } outSel_e;

  // Source code field of the configuration register
  localparam logic [1:0] SRC_MSG = 2'b01;
  localparam logic [1:0] SRC_FIX = 2'b10;

  // Strobes from control to datapath
  typedef struct packed {
    logic    msgWr;
    logic    fixWr;
    logic    idxClear;
    logic    emit;
    logic    advance;
    outSel_e outSel;
  } dpCmd_t;

endpackage

// File: rtl/j1_trace_ctrl.sv
module j1_trace_ctrl
  import j1_trace_pkg::*;
#(
  parameter int MSG_DEPTH = 64,
  parameter int MID_LEN   = 16,
  localparam int IDX_W    = $clog2(MSG_DEPTH),
  localparam int ADDR_W   = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        hostWdata,
  input  logic              speStrobe,
  input  logic [7:0]        msgRdByte,
  input  logic [7:0]        fixByte,
  output logic [7:0]        hostRdata,
  output dpCmd_t            cmd,
  output logic [1:0]        cfgSrc,
  output logic [IDX_W-1:0]  lastIdx
);

  localparam logic [ADDR_W-1:0] CFG_ADDR  = ADDR_W'(MSG_DEPTH);
  localparam logic [ADDR_W-1:0] FIX_ADDR  = ADDR_W'(MSG_DEPTH + 1);
  localparam logic [IDX_W-1:0]  LAST_ONE  = '0;
  localparam logic [IDX_W-1:0]  LAST_MID  = IDX_W'(MID_LEN - 1);
  localparam logic [IDX_W-1:0]  LAST_FULL = IDX_W'(MSG_DEPTH - 1);

  logic [3:0] cfgReg;
  logic       cfgHit;
  logic       msgHit;
  logic       fixHit;

  assign cfgHit = (hostAddr == CFG_ADDR);
  assign fixHit = (hostAddr == FIX_ADDR);
  assign msgHit = (hostAddr < CFG_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (hostWe && cfgHit) begin
      cfgReg <= hostWdata[3:0];
    end
  end

  assign cfgSrc = cfgReg[1:0];

  always_comb begin
    unique case (cfgReg[3:2])
      2'b00:   lastIdx = LAST_ONE;
      2'b01:   lastIdx = LAST_MID;
      default: lastIdx = LAST_FULL;
    endcase
  end

  always_comb begin
    cmd.msgWr    = hostWe && msgHit;
    cmd.fixWr    = hostWe && fixHit;
    cmd.idxClear = hostWe && cfgHit;
    cmd.emit     = speStrobe;
    cmd.advance  = speStrobe && (cfgSrc == SRC_MSG);
    if (cfgSrc == SRC_MSG)      cmd.outSel = SEL_MSG;
    else if (cfgSrc == SRC_FIX) cmd.outSel = SEL_FIX;
    else                        cmd.outSel = SEL_ZERO;
  end

  always_comb begin
    if (msgHit)      hostRdata = msgRdByte;
    else if (cfgHit) hostRdata = {4'b0000, cfgReg};
    else if (fixHit) hostRdata = fixByte;
    else             hostRdata = 8'h00;
  end

endmodule

// File: rtl/j1_trace_dp.sv
module j1_trace_dp
  import j1_trace_pkg::*;
#(
  parameter int MSG_DEPTH = 64,
  localparam int IDX_W    = $clog2(MSG_DEPTH),
  localparam int ADDR_W   = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        hostWdata,
  input  logic [IDX_W-1:0]  lastIdx,
  output logic [7:0]        msgRdByte,
  output logic [7:0]        fixByte,
  output logic [IDX_W-1:0]  rdIdx,
  output logic [7:0]        j1Byte,
  output logic              j1Valid
);

  logic [7:0]       msgMem [MSG_DEPTH];
  logic [IDX_W-1:0] hostIdx;
  logic [7:0]       nextByte;

  assign hostIdx   = hostAddr[IDX_W-1:0];
  assign msgRdByte = msgMem[hostIdx];

  // Message store: one write port for the host
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MSG_DEPTH; i++) msgMem[i] <= 8'h00;
    end else if (cmd.msgWr) begin
      msgMem[hostIdx] <= hostWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          fixByte <= 8'h00;
    else if (cmd.fixWr) fixByte <= hostWdata;
  end

  // Read index: restart has priority over stepping
  always_ff @(posedge clk) begin
    if (!rstN)             rdIdx <= '0;
    else if (cmd.idxClear) rdIdx <= '0;
    else if (cmd.advance)  rdIdx <= (rdIdx == lastIdx) ? '0 : rdIdx + 1'b1;
  end

  // Pre-edge values are taken, so a colliding write shows the old byte
  always_comb begin
    unique case (cmd.outSel)
      SEL_MSG: nextByte = msgMem[rdIdx];
      SEL_FIX: nextByte = fixByte;
      default: nextByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      j1Byte  <= 8'h00;
      j1Valid <= 1'b0;
    end else begin
      j1Valid <= cmd.emit;
      if (cmd.emit) j1Byte <= nextByte;
    end
  end

endmodule

// File: rtl/j1_trace_seq.sv
module j1_trace_seq
  import j1_trace_pkg::*;
#(
  parameter int MSG_DEPTH = 64,
  parameter int MID_LEN   = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       hostWe,
  input  logic [$clog2(MSG_DEPTH):0] hostAddr,
  input  logic [7:0]                 hostWdata,
  output logic [7:0]                 hostRdata,
  input  logic                       speStrobe,
  output logic [7:0]                 j1Byte,
  output logic                       j1Valid
);

  localparam int IDX_W = $clog2(MSG_DEPTH);

  dpCmd_t           cmd;
  logic [1:0]       cfgSrc;
  logic [IDX_W-1:0] lastIdx;
  logic [IDX_W-1:0] rdIdx;
  logic [7:0]       msgRdByte;
  logic [7:0]       fixByte;

  j1_trace_ctrl #(.MSG_DEPTH(MSG_DEPTH), .MID_LEN(MID_LEN)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostWe    (hostWe),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .speStrobe (speStrobe),
    .msgRdByte (msgRdByte),
    .fixByte   (fixByte),
    .hostRdata (hostRdata),
    .cmd       (cmd),
    .cfgSrc    (cfgSrc),
    .lastIdx   (lastIdx)
  );

  j1_trace_dp #(.MSG_DEPTH(MSG_DEPTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .lastIdx   (lastIdx),
    .msgRdByte (msgRdByte),
    .fixByte   (fixByte),
    .rdIdx     (rdIdx),
    .j1Byte    (j1Byte),
    .j1Valid   (j1Valid)
  );

endmodule

// File: rtl/j1_trace_chk.sv
module j1_trace_chk #(
  parameter int MSG_DEPTH = 64,
  localparam int IDX_W    = $clog2(MSG_DEPTH),
  localparam int ADDR_W   = IDX_W + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWe,
  input logic [ADDR_W-1:0] hostAddr,
  input logic [7:0]        hostRdata,
  input logic              speStrobe,
  input logic [7:0]        j1Byte,
  input logic              j1Valid,
  input logic [1:0]        cfgSrc,
  input logic [IDX_W-1:0]  rdIdx,
  input logic [IDX_W-1:0]  lastIdx
);

  localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(MSG_DEPTH);

  logic cfgWrite;
  logic zeroSrc;
  assign cfgWrite = hostWe && (hostAddr == CFG_ADDR);
  assign zeroSrc  = (cfgSrc == 2'b00) || (cfgSrc == 2'b11);

  // R8
  valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    speStrobe |=> j1Valid);

  // R8
  valid_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    !speStrobe |=> !j1Valid);

  // R8
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !speStrobe |=> $stable(j1Byte));

  // R6
  zero_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (speStrobe && zeroSrc) |=> (j1Byte == 8'h00));

  // R6
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (zeroSrc && !cfgWrite) |=> $stable(rdIdx));

  // R7
  idx_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> (rdIdx == '0));

  // R4
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdIdx <= lastIdx);

  // R2
  cfg_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostAddr == CFG_ADDR) |-> (hostRdata[7:4] == 4'h0));

endmodule

bind j1_trace_seq j1_trace_chk #(.MSG_DEPTH(MSG_DEPTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hostWe    (hostWe),
  .hostAddr  (hostAddr),
  .hostRdata (hostRdata),
  .speStrobe (speStrobe),
  .j1Byte    (j1Byte),
  .j1Valid   (j1Valid),
  .cfgSrc    (cfgSrc),
  .rdIdx     (rdIdx),
  .lastIdx   (lastIdx)
);

// File: tb/sim_j1_trace_seq.sv
module sim_j1_trace_seq;

  localparam int DEPTH = 64;
  localparam int CFG   = 64;
  localparam int FIX   = 65;

  logic       clk = 1'b0;
  logic       rstN;
  logic       hostWe;
  logic [6:0] hostAddr;
  logic [7:0] hostWdata;
  logic [7:0] hostRdata;
  logic       speStrobe;
  logic [7:0] j1Byte;
  logic       j1Valid;

  always #2 clk = ~clk;

  j1_trace_seq u0 (
    .clk       (clk),
    .rstN      (rstN),
    .hostWe    (hostWe),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .hostRdata (hostRdata),
    .speStrobe (speStrobe),
    .j1Byte    (j1Byte),
    .j1Valid   (j1Valid)
  );

  int    total = 0;
  int    bad   = 0;
  string req   = "R1";

  // Behavioural reference model
  logic [7:0] mMem [DEPTH];
  int         mIdx;
  logic [3:0] mCfg;
  logic [7:0] mFix;
  logic [7:0] mByte;
  logic       mValid;

  function automatic int mLen();
    case (mCfg[3:2])
      2'b00:   return 1;
      2'b01:   return 16;
      default: return 64;
    endcase
  endfunction

  function automatic logic [7:0] mRead(int a);
    if (a < DEPTH)   return mMem[a];
    if (a == CFG)    return {4'h0, mCfg};
    if (a == FIX)    return mFix;
    return 8'h00;
  endfunction

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, let the rising edge act, compare at the next falling edge
  task automatic step(bit we, int addr, logic [7:0] d, bit stb);
    hostWe    = we;
    hostAddr  = 7'(addr);
    hostWdata = d;
    speStrobe = stb;
    if (stb) begin
      case (mCfg[1:0])
        2'b01:   mByte = mMem[mIdx];
        2'b10:   mByte = mFix;
        default: mByte = 8'h00;
      endcase
      mValid = 1'b1;
    end else begin
      mValid = 1'b0;
    end
    if (we && addr == CFG) mIdx = 0;
    else if (stb && mCfg[1:0] == 2'b01) mIdx = (mIdx == mLen() - 1) ? 0 : mIdx + 1;
    if (we) begin
      if (addr < DEPTH)     mMem[addr] = d;
      else if (addr == CFG) mCfg = d[3:0];
      else if (addr == FIX) mFix = d;
    end
    @(negedge clk);
    check(req, "j1Byte", j1Byte, mByte);
    check(req, "j1Valid", {7'd0, j1Valid}, {7'd0, mValid});
    check(req, "hostRdata", hostRdata, mRead(addr));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, 0);
  endtask

  task automatic strobes(int n, int gap);
    for (int i = 0; i < n; i++) begin
      step(0, CFG, 8'h00, 1);
      if (gap > 0) idle(gap);
    end
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mMem[i] = 8'h00;
    mIdx = 0; mCfg = 4'h0; mFix = 8'h00; mByte = 8'h00; mValid = 1'b0;
    rstN = 1'b0; hostWe = 1'b0; hostAddr = '0; hostWdata = '0; speStrobe = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    req = "R1";
    check(req, "j1Byte", j1Byte, 8'h00);
    check(req, "j1Valid", {7'd0, j1Valid}, 8'h00);
    step(0, CFG, 8'h00, 0);
    step(0, FIX, 8'h00, 0);
    step(0, 5, 8'h00, 0);

    // R10: fill the message store and read it back, including unmapped addresses
    req = "R10";
    for (int i = 0; i < DEPTH; i++) step(1, i, 8'(i * 37 + 11), 0);
    for (int i = 0; i < DEPTH; i += 7) step(0, i, 8'h00, 0);
    step(0, 66, 8'h00, 0);
    step(0, 127, 8'h00, 0);

    // R2: upper configuration bits never stick (write 0xF5 -> reads 0x05)
    req = "R2";
    step(1, CFG, 8'hF5, 0);
    step(0, CFG, 8'h00, 0);

    // R4 / R3: 16-byte message, source code 01, wraps after 15
    req = "R4";
    strobes(20, 1);
    req = "R3";
    strobes(20, 0);

    // R3: length code 00 -> one byte repeated
    req = "R3";
    step(1, CFG, 8'h01, 0);
    strobes(4, 2);

    // R3: length codes 10 and 11 -> 64 bytes
    step(1, CFG, 8'h09, 0);
    strobes(70, 0);
    step(1, CFG, 8'h0D, 0);
    strobes(68, 1);

    // R5: fixed byte source
    req = "R5";
    step(1, FIX, 8'hA5, 0);
    step(1, CFG, 8'h02, 0);
    strobes(3, 1);

    // R9: fixed byte rewritten in the strobe cycle shows the old byte first
    req = "R9";
    step(1, FIX, 8'h3C, 1);
    strobes(2, 0);

    // R6: zero sources 00 and 11
    req = "R6";
    step(1, CFG, 8'h04, 0);
    strobes(3, 1);
    step(1, CFG, 8'h07, 0);
    strobes(3, 0);

    // R7: restart on rewrite of the same value, and on a write in a strobe cycle
    req = "R7";
    step(1, CFG, 8'h05, 0);
    strobes(5, 0);
    step(1, CFG, 8'h05, 0);
    strobes(3, 0);
    step(1, CFG, 8'h05, 1);
    strobes(3, 0);

    // R9: message entry rewritten while it is being read
    req = "R9";
    step(1, CFG, 8'h05, 0);
    strobes(3, 0);
    step(1, 3, 8'hEE, 1);
    strobes(16, 0);

    // R8: back-to-back strobes and long gaps
    req = "R8";
    strobes(6, 0);
    strobes(3, 4);
    idle(5);

    finishRun();
  end

endmodule